// File: doc/BRIEF.md
# Infrared Remote Frame Status Flags

This block holds the frame-level status of an infrared remote-control receiver. An upstream pulse-width classifier sends it one-cycle strobes for each symbol it recognises: a header, a data 0, a data 1, a special symbol, or a width that fits none of them. The same classifier also supplies a strobe for each received bit, together with that bit's value. A level input stays high while a frame is being received. Its rising edge marks the start of a new frame.

Received bits are stored in order of arrival. Bit k of a frame is written to position k of a 48-bit data register. After 48 bits the write position wraps to 0 and the next segment overwrites the register from the bottom.

Two flags are kept. The compare flag reports that the low n+1 bits of the frame equal a programmed value, where n is a 3-bit compare length. The error flag reports malformed symbol sequences. Its rules are chosen by two configuration bits: one requires a header, and the other makes the error sticky. Both flags are registered, and each updates on the clock edge that samples the causing strobe.

Top module: `irrx_status_flags`

## Requirements
- R1: When a bit strobe is accepted, its value is written to `rx_data[bit_index]` and `bit_index` advances by one. After index 47, `bit_index` wraps to 0 and later bits overwrite the register starting from bit 0.
- R2: A rising edge of `frame_rx` clears `rx_data`, `bit_index`, `cmp_match`, `rx_error` and the internal header-seen state. A bit strobe arriving in that same cycle is dropped.
- R3: While `enable` is 0, `bit_index` is held at 0 and both flags are held at 0. Bit strobes and symbol strobes are ignored, and `rx_data` keeps its contents.
- R4: While `cmp_enable` is 0, `cmp_match` is held at 0. Re-enabling the compare does not restore an earlier match.
- R5: Let n be the value of `cmp_len`. When the bit with index n is accepted and bits n..0 of the data (including that bit) equal bits n..0 of `cmp_value`, `cmp_match` becomes 1 on that edge. A difference in bit n alone prevents the match.
- R6: When the 48th bit of a segment is accepted, `cmp_match` clears if no compare match occurred in that segment. If a match occurred in that segment, `cmp_match` stays 1.
- R7: With `err_hold`=0 and `hdr_enable`=0, an invalid width or a header sets `rx_error`. A valid data symbol clears it.
- R8: With `err_hold`=0 and `hdr_enable`=1, `rx_error` is set by an invalid width, or by a data symbol that arrives before a header in the current frame. Only a header clears it; data symbols leave it unchanged.
- R9: With `err_hold`=1 and `hdr_enable`=0, an invalid width or a header sets `rx_error`. No symbol clears it; only rule R2 or R3 does.
- R10: With `err_hold`=1 and `hdr_enable`=1, the set and clear rules of R8 apply. Header-seen state is cleared at each frame start.
- R11: The special symbol counts as valid data only while `spec_enable` is 1. While `spec_enable` is 0 it acts as an invalid width.
- R12: When a clearing event and a setting event for a flag arrive in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable |
| hdr_enable | input | 1 | Header required before data |
| err_hold | input | 1 | Error flag is not cleared by symbols |
| spec_enable | input | 1 | Special symbol counts as valid data |
| cmp_enable | input | 1 | Compare flag enable |
| cmp_len | input | 3 | Index n of the highest compared bit |
| cmp_value | input | 48 | Compare value |
| frame_rx | input | 1 | High while a frame is being received |
| sym_header | input | 1 | Header strobe |
| sym_data0 | input | 1 | Data 0 strobe |
| sym_data1 | input | 1 | Data 1 strobe |
| sym_special | input | 1 | Special symbol strobe |
| sym_invalid | input | 1 | Invalid width strobe |
| bit_valid | input | 1 | Received bit strobe |
| bit_value | input | 1 | Value of the received bit |
| rx_data | output | 48 | Received data register |
| bit_index | output | 6 | Next write position |
| cmp_match | output | 1 | Compare match flag |
| rx_error | output | 1 | Receive error flag |

## Verification
The bench targets the 48-bit segment rule from both sides:
- A segment whose low bits matched must keep the flag. A design that clears on every 48th bit would drop it there.
- A following segment that does not match must clear the flag, which a design that never re-arms would leave set.

Compare boundaries use n=3 and n=7, including a frame that differs only in bit n. An off-by-one mask would report a false match.

Each error mode is driven with data before a header, a header with headers disabled, and data arriving on a sticky flag. A wrong mode decode shows up as an error flag that clears or sets on the wrong symbol. The bench also sends simultaneous set and clear strobes, and a bit strobe in the frame-start cycle, to catch priority mistakes.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
  // Error rule selection, packed as {err_hold, hdr_enable}
  typedef enum logic [1:0] {
    ERRM_FREE       = 2'b00,
    ERRM_HDR        = 2'b01,
    ERRM_STICKY     = 2'b10,
    ERRM_STICKY_HDR = 2'b11
  } err_mode_e;

  localparam int unsigned SEG_BITS = 48;
  localparam int unsigned LEN_BITS = 3;
endpackage

// File: rtl/irrx_bit_store.sv
module irrx_bit_store #(
  parameter int unsigned DATA_W = 48,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              bit_valid,
  input  logic              bit_value,
  output logic [DATA_W-1:0] data_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              bit_take,
  output logic              seg_end
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] data_n;
  logic [IDX_W-1:0]  idx_n;
  logic              upd_en;

  always_comb begin
    data_n   = data_q;
    idx_n    = idx_q;
    bit_take = enable & ~frame_start & bit_valid;
    seg_end  = bit_take & (idx_q == LAST_IDX);
    upd_en   = ~enable | frame_start | bit_valid;
    if (!enable) begin
      idx_n = '0;
    end else if (frame_start) begin
      data_n = '0;
      idx_n  = '0;
    end else if (bit_valid) begin
      data_n[idx_q] = bit_value;
      idx_n         = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      idx_q  <= '0;
    end else if (upd_en) begin
      data_q <= data_n;
      idx_q  <= idx_n;
    end
  end

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_take && idx_q == LAST_IDX) |=> (idx_q == '0));

  assert_idle_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (idx_q == '0));
endmodule

// File: rtl/irrx_cmp_flag.sv
module irrx_cmp_flag #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LEN_W = 3,
  localparam int unsigned SPAN = 1 << LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cmp_en,
  input  logic             frame_start,
  input  logic             bit_take,
  input  logic             seg_end,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_value,
  input  logic [LEN_W-1:0] cmp_len,
  input  logic [SPAN-1:0]  data_low,
  input  logic [SPAN-1:0]  cmp_low,
  output logic             match_q
);
  logic [SPAN-1:0] cand;
  logic [SPAN-1:0] mask;
  logic            hit;
  logic            seg_hit_q, seg_hit_n, match_n;

  always_comb begin
    cand          = data_low;
    cand[cmp_len] = bit_value;
    for (int k = 0; k < SPAN; k++) begin
      mask[k] = (LEN_W'(k) <= cmp_len);
    end
    hit = bit_take && (bit_idx == IDX_W'(cmp_len)) &&
          (((cand ^ cmp_low) & mask) == '0);
  end

  always_comb begin
    match_n   = match_q;
    seg_hit_n = seg_hit_q;
    if (!enable || !cmp_en || frame_start) begin
      match_n   = 1'b0;
      seg_hit_n = 1'b0;
    end else if (seg_end) begin
      match_n   = match_q & seg_hit_q;
      seg_hit_n = 1'b0;
    end else if (hit) begin
      match_n   = 1'b1;
      seg_hit_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= 1'b0;
      seg_hit_q <= 1'b0;
    end else begin
      match_q   <= match_n;
      seg_hit_q <= seg_hit_n;
    end
  end

  assert_cmp_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> !match_q);

  assert_cmp_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !match_q);

  assert_seg_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && !seg_hit_q) |=> !match_q);
endmodule

// File: rtl/irrx_err_flag.sv
module irrx_err_flag
  import irrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic frame_start,
  input  logic hdr_en,
  input  logic hold,
  input  logic spec_en,
  input  logic s_hdr,
  input  logic s_d0,
  input  logic s_d1,
  input  logic s_sp,
  input  logic s_inv,
  output logic err_q
);
  err_mode_e mode;
  logic      valid_d, bad, set_ev, clr_ev;
  logic      hs_q, hs_n, err_n;

  always_comb begin
    mode    = err_mode_e'({hold, hdr_en});
    valid_d = s_d0 | s_d1 | (s_sp & spec_en);
    bad     = s_inv | (s_sp & ~spec_en) | (s_hdr & ~hdr_en);
    unique case (mode)
      ERRM_FREE:                 begin set_ev = bad; clr_ev = valid_d; end
      ERRM_STICKY:               begin set_ev = bad; clr_ev = 1'b0;    end
      ERRM_HDR, ERRM_STICKY_HDR: begin
        set_ev = bad | (valid_d & ~hs_q);
        clr_ev = s_hdr;
      end
      default:                   begin set_ev = 1'b0; clr_ev = 1'b0; end
    endcase
    if (!enable || frame_start) begin
      hs_n  = 1'b0;
      err_n = 1'b0;
    end else begin
      hs_n  = hs_q | (s_hdr & hdr_en);
      err_n = clr_ev ? 1'b0 : (set_ev | err_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      hs_q  <= 1'b0;
    end else begin
      err_q <= err_n;
      hs_q  <= hs_n;
    end
  end

  assert_err_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || frame_start) |=> !err_q);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !frame_start && hold && !hdr_en && err_q) |=> err_q);

  assert_invalid_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !frame_start && s_inv && !(s_d0 | s_d1 | s_sp | s_hdr)) |=> err_q);
endmodule

// File: rtl/irrx_status_flags.sv
module irrx_status_flags
  import irrx_pkg::*;
#(
  parameter int unsigned DATA_W = SEG_BITS,
  parameter int unsigned LEN_W  = LEN_BITS,
  localparam int unsigned IDX_W = $clog2(DATA_W),
  localparam int unsigned SPAN  = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hdr_enable,
  input  logic              err_hold,
  input  logic              spec_enable,
  input  logic              cmp_enable,
  input  logic [LEN_W-1:0]  cmp_len,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              frame_rx,
  input  logic              sym_header,
  input  logic              sym_data0,
  input  logic              sym_data1,
  input  logic              sym_special,
  input  logic              sym_invalid,
  input  logic              bit_valid,
  input  logic              bit_value,
  output logic [DATA_W-1:0] rx_data,
  output logic [IDX_W-1:0]  bit_index,
  output logic              cmp_match,
  output logic              rx_error
);
  logic frame_q, frame_start, bit_take, seg_end;

  assign frame_start = frame_rx & ~frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_rx;
  end

  irrx_bit_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .bit_valid(bit_valid), .bit_value(bit_value), .data_q(rx_data),
    .idx_q(bit_index), .bit_take(bit_take), .seg_end(seg_end)
  );

  irrx_cmp_flag #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_en(cmp_enable),
    .frame_start(frame_start), .bit_take(bit_take), .seg_end(seg_end),
    .bit_idx(bit_index), .bit_value(bit_value), .cmp_len(cmp_len),
    .data_low(rx_data[SPAN-1:0]), .cmp_low(cmp_value[SPAN-1:0]),
    .match_q(cmp_match)
  );

  irrx_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_start(frame_start),
    .hdr_en(hdr_enable), .hold(err_hold), .spec_en(spec_enable),
    .s_hdr(sym_header), .s_d0(sym_data0), .s_d1(sym_data1),
    .s_sp(sym_special), .s_inv(sym_invalid), .err_q(rx_error)
  );

  assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_index == '0 && rx_data == '0 && !cmp_match && !rx_error));
endmodule

// File: tb/irrx_status_flags_tb.sv
module irrx_status_flags_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 0, hdr_enable = 0, err_hold = 0, spec_enable = 0, cmp_enable = 0;
  logic [2:0]  cmp_len = '0;
  logic [47:0] cmp_value = '0;
  logic        frame_rx = 0, sym_header = 0, sym_data0 = 0, sym_data1 = 0;
  logic        sym_special = 0, sym_invalid = 0, bit_valid = 0, bit_value = 0;
  logic [47:0] rx_data;
  logic [5:0]  bit_index;
  logic        cmp_match, rx_error;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string       req;
    int          c;
    int          e;
    int          i;
    bit          dchk;
    logic [47:0] d;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irrx_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hdr_enable(hdr_enable),
    .err_hold(err_hold), .spec_enable(spec_enable), .cmp_enable(cmp_enable),
    .cmp_len(cmp_len), .cmp_value(cmp_value), .frame_rx(frame_rx),
    .sym_header(sym_header), .sym_data0(sym_data0), .sym_data1(sym_data1),
    .sym_special(sym_special), .sym_invalid(sym_invalid), .bit_valid(bit_valid),
    .bit_value(bit_value), .rx_data(rx_data), .bit_index(bit_index),
    .cmp_match(cmp_match), .rx_error(rx_error)
  );

  // Monitor: pops one expectation per clock edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        if (it.c >= 0) begin
          checks++;
          if (cmp_match !== it.c[0]) begin
            fails++;
            $display("FAIL %s cmp_match actual %0b expected %0d", it.req, cmp_match, it.c);
          end
        end
        if (it.e >= 0) begin
          checks++;
          if (rx_error !== it.e[0]) begin
            fails++;
            $display("FAIL %s rx_error actual %0b expected %0d", it.req, rx_error, it.e);
          end
        end
        if (it.i >= 0) begin
          checks++;
          if (bit_index !== it.i[5:0]) begin
            fails++;
            $display("FAIL %s bit_index actual %0d expected %0d", it.req, bit_index, it.i);
          end
        end
        if (it.dchk) begin
          checks++;
          if (rx_data !== it.d) begin
            fails++;
            $display("FAIL %s rx_data actual %h expected %h", it.req, rx_data, it.d);
          end
        end
      end
    end
  end

  // Driver: inputs set before the call apply at the next rising edge
  task automatic step(string req, int c, int e, int i = -1, bit dchk = 1'b0,
                      logic [47:0] d = '0);
    exp_t it;
    it.req = req; it.c = c; it.e = e; it.i = i; it.dchk = dchk; it.d = d;
    q.push_back(it);
    @(negedge clk);
    sym_header = 0; sym_data0 = 0; sym_data1 = 0; sym_special = 0;
    sym_invalid = 0; bit_valid = 0; bit_value = 0;
  endtask

  task automatic send_word(string req, logic [63:0] v, int cnt, int c, int i,
                           bit dchk = 1'b0, logic [47:0] d = '0);
    for (int k = 0; k < cnt; k++) begin
      bit_valid = 1'b1;
      bit_value = v[k];
      if (k == cnt - 1) step(req, c, -1, i, dchk, d);
      else              step("", -1, -1);
    end
  endtask

  task automatic frame_restart(string req);
    frame_rx = 1'b0;
    step("", -1, -1);
    frame_rx = 1'b1;
    step(req, 0, 0, 0, 1'b1, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("reset", 0, 0, 0, 1'b1, '0);

    // Compare with n=3, value low bits 0101
    enable = 1; cmp_enable = 1; cmp_len = 3'd3; cmp_value = 48'h5;
    frame_restart("R2 frame start");
    send_word("R5 before bit n", 64'h5, 3, 0, 3);
    send_word("R5 match at bit n R1", 64'h0, 1, 1, 4, 1'b1, 48'h5);
    send_word("R6 before segment end", 64'h0, 43, 1, 47);
    send_word("R6 matched segment keeps R1 wrap", 64'h0, 1, 1, 0, 1'b1, 48'h5);
    send_word("R1 overwrite bit 0", 64'h0, 1, 1, 1, 1'b1, 48'h4);
    send_word("R6 unmatched segment before end", 64'h0, 46, 1, 47);
    send_word("R6 unmatched segment clears", 64'h0, 1, 0, 0);

    // R4: compare disable
    frame_restart("R2");
    send_word("R5", 64'h5, 4, 1, 4);
    cmp_enable = 0;
    step("R4 disabled", 0, -1);
    cmp_enable = 1;
    step("R4 no restore", 0, -1);

    // n=7, differ only in bit 7
    cmp_len = 3'd7; cmp_value = 48'hA5;
    frame_restart("R2");
    send_word("R5 bit n mismatch", 64'h25, 8, 0, 8);
    frame_restart("R2");
    send_word("R5 full match n=7", 64'hA5, 8, 1, 8, 1'b1, 48'hA5);
    frame_rx = 1'b0;
    step("", -1, -1);
    frame_rx = 1'b1; bit_valid = 1'b1; bit_value = 1'b1;
    step("R2 bit dropped R12", 0, 0, 0, 1'b1, '0);

    // R3: disable
    send_word("R5", 64'hA5, 8, 1, 8);
    enable = 0; bit_valid = 1'b1; bit_value = 1'b1; sym_invalid = 1'b1;
    step("R3 disabled", 0, 0, 0, 1'b1, 48'hA5);
    sym_invalid = 1'b1;
    step("R3 strobe ignored", 0, 0, 0);
    enable = 1;

    // R7 / R11 / R12: hold 0, header 0
    cmp_enable = 0; hdr_enable = 0; err_hold = 0; spec_enable = 0;
    frame_restart("R2");
    sym_invalid = 1; step("R7 invalid sets", -1, 1);
    sym_data0 = 1;   step("R7 data0 clears", -1, 0);
    sym_header = 1;  step("R7 header sets", -1, 1);
    sym_data1 = 1;   step("R7 data1 clears", -1, 0);
    spec_enable = 1;
    sym_invalid = 1; step("R7", -1, 1);
    sym_special = 1; step("R11 special valid clears", -1, 0);
    spec_enable = 0;
    sym_special = 1; step("R11 special invalid sets", -1, 1);
    sym_data0 = 1;   step("R7", -1, 0);
    sym_invalid = 1; sym_data0 = 1; step("R12 clear beats set", -1, 0);

    // R8: hold 0, header 1
    hdr_enable = 1;
    frame_restart("R2");
    sym_data0 = 1;   step("R8 data before header", -1, 1);
    sym_header = 1;  step("R8 header clears", -1, 0);
    sym_data1 = 1;   step("R8 data after header", -1, 0);
    sym_invalid = 1; step("R8 invalid sets", -1, 1);
    sym_data0 = 1;   step("R8 data does not clear", -1, 1);
    sym_header = 1;  step("R8", -1, 0);
    sym_special = 1; step("R11 special invalid R8", -1, 1);
    sym_header = 1; sym_invalid = 1; step("R12 header beats invalid", -1, 0);

    // R9: hold 1, header 0
    hdr_enable = 0; err_hold = 1;
    frame_restart("R2");
    sym_data0 = 1;   step("R9 data alone", -1, 0);
    sym_invalid = 1; step("R9 invalid sets", -1, 1);
    sym_data0 = 1;   step("R9 data0 sticky", -1, 1);
    sym_data1 = 1;   step("R9 data1 sticky", -1, 1);
    sym_header = 1;  step("R9 header sticky", -1, 1);
    frame_restart("R2 sticky cleared");

    // R10: hold 1, header 1
    hdr_enable = 1;
    sym_data1 = 1;   step("R10 data before header", -1, 1);
    sym_header = 1;  step("R10 header clears", -1, 0);
    sym_data0 = 1;   step("R10 data after header", -1, 0);
    sym_invalid = 1; step("R10 invalid sets", -1, 1);
    sym_data1 = 1;   step("R10 data sticky", -1, 1);
    sym_header = 1;  step("R10", -1, 0);
    frame_restart("R2");
    sym_data0 = 1;   step("R10 header-seen reset at frame", -1, 1);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule